// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM out of power-on into a usable state. When a start request arrives with a legal configuration, it first waits out a programmable power-stabilisation period. It then drives a fixed command series onto the memory control pins: one precharge-all-banks, a run of auto-refresh commands, and a mode-register-set. The mode value for the device travels on the address lines. After a final settling delay it raises a sticky completion flag.

The configuration selects the target memory area, the external bus width (32 or 64 bits), the burst length and the CAS latency. The config is captured when the start request is accepted. Later changes on the config inputs do not alter a sequence already under way. A configuration the device cannot take raises an error flag, and the sequencer then stays waiting. A synthesis parameter lets the idle wait be skipped when the reset pulse already outlasts the device's stabilisation time.

Top module: `sdram_init_seq`

## Requirements
- R1: While and after reset, before any start request, {cs_n,ras_n,cas_n,we_n} is 4'b0111 (NOP), addr is 0, done is 0 and cfg_err is 0.
- R2: When start is sampled high in the waiting state with a legal configuration, the precharge-all command appears IDLE_CYC+1 cycles later. With SKIP_IDLE=1 it appears 1 cycle later.
- R3: The only commands issued are, in this order: one precharge-all, the refresh run, one mode-register-set. In every other cycle the pins carry NOP and addr is 0.
- R4: The refresh run contains REF_CNT auto-refresh commands, or 8 if REF_CNT is below 8.
- R5: There are exactly T_RP NOP cycles after precharge-all and T_RFC NOP cycles after each auto-refresh. done rises T_MRD+1 cycles after the mode-register-set cycle.
- R6: cfg_area3=0 selects base 0xFF900000 and cfg_area3=1 selects base 0xFF940000. Precharge-all drives base+0x400 (address bit 10 set) and auto-refresh drives base. The mode-register-set drives base + (M << S), where M = cfg_cl*16 + 2 (CAS latency in bits 6:4, bit 3 = 0 for sequential wrap, burst field 010), and S is 2 for a 32-bit bus (cfg_bus64=0) or 3 for a 64-bit bus. For example, 32-bit with CL1 gives offset 0x48, and 64-bit with CL1 gives offset 0x90.
- R7: The active-low command codes on {cs_n,ras_n,cas_n,we_n} are: precharge-all 4'b0010, auto-refresh 4'b0001, mode-register-set 4'b0000.
- R8: done stays high until reset. A start request while the sequence runs or after done has no effect: no extra command appears, and the captured configuration is kept.
- R9: A configuration is illegal if cfg_cl is 0, or if cfg_bl8 (1 = burst 8, 0 = burst 4) differs from cfg_bus64. A start with an illegal configuration sets cfg_err in the cycle after start is sampled, and no command is issued. A later start with a legal configuration clears cfg_err and runs the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin the initialization series |
| cfg_area3 | input | 1 | Target area: 0 = lower window, 1 = upper window |
| cfg_bus64 | input | 1 | External bus width: 0 = 32 bits, 1 = 64 bits |
| cfg_bl8 | input | 1 | Burst length: 0 = 4, 1 = 8 |
| cfg_cl | input | 2 | CAS latency 1 to 3; 0 is illegal |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address lines carrying bank select or the mode value |
| done | output | 1 | Initialization complete, sticky |
| cfg_err | output | 1 | Last start request carried an illegal configuration |

## Verification
The bench builds two instances side by side. The first has an idle wait of 25 cycles, nine refreshes and unequal gaps (2, 4, 3), so every delay counter and a refresh count above the minimum are each exercised. The second skips the idle wait, asks for only three refreshes and uses one-cycle gaps. That brings the clamp to eight refreshes and back-to-back command spacing within reach. Random legal configurations over both areas, both bus widths and all three latencies are mixed with illegal configurations and with start pulses issued mid-sequence and after completion.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Active-low {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PALL = 4'b0010,
    CMD_NOP  = 4'b0111
  } cmd_t;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PWR,
    ST_RP,
    ST_RFC,
    ST_MRD,
    ST_DONE
  } state_t;

  function automatic logic cfg_legal(logic bus64, logic bl8, logic [1:0] cl);
    return (cl != 2'd0) && (bl8 == bus64);
  endfunction

endpackage

// File: rtl/sdram_cfg_chk.sv
module sdram_cfg_chk #(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] AREA2_BASE = 32'hFF90_0000,
  parameter logic [31:0] AREA3_BASE = 32'hFF94_0000
) (
  input  logic              area3,
  input  logic              bus64,
  input  logic [1:0]        cl,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] mrs_addr
);
  localparam int MODE_W = 8;
  localparam int OFS_W  = MODE_W + 3;

  logic [MODE_W-1:0] mode_word;
  logic [OFS_W-1:0]  offset;

  always_comb begin
    // CAS latency in 6:4, sequential wrap (bit 3 = 0), burst field 010
    mode_word = {2'b00, cl, 1'b0, 3'b010};
    offset    = bus64 ? {mode_word, 3'b000} : {1'b0, mode_word, 2'b00};
    base      = area3 ? ADDR_W'(AREA3_BASE) : ADDR_W'(AREA2_BASE);
    mrs_addr  = base + ADDR_W'(offset);
  end

endmodule

// File: rtl/sdram_wait_cnt.sv
module sdram_wait_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          IDLE_CYC   = 20000,
  parameter bit          SKIP_IDLE  = 1'b0,
  parameter int          REF_CNT    = 8,
  parameter int          T_RP       = 2,
  parameter int          T_RFC      = 7,
  parameter int          T_MRD      = 2,
  parameter logic [31:0] AREA2_BASE = 32'hFF90_0000,
  parameter logic [31:0] AREA3_BASE = 32'hFF94_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cfg_area3,
  input  logic              cfg_bus64,
  input  logic              cfg_bl8,
  input  logic [1:0]        cfg_cl,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              cfg_err
);
  localparam int REF_N   = (REF_CNT < 8) ? 8 : REF_CNT;
  localparam int REF_W   = $clog2(REF_N + 1);
  localparam int IDLE_LD = SKIP_IDLE ? 0 : IDLE_CYC;
  localparam int MAX_A   = (IDLE_LD > T_RP) ? IDLE_LD : T_RP;
  localparam int MAX_B   = (T_RFC > T_MRD) ? T_RFC : T_MRD;
  localparam int MAX_W   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = (MAX_W < 2) ? 1 : $clog2(MAX_W + 1);
  localparam logic [ADDR_W-1:0] A10 = ADDR_W'(1) << 10;

  state_t            state_q;
  cmd_t              cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q, err_q;
  logic [REF_W-1:0]  ref_q;
  logic              area3_q, bus64_q;
  logic [1:0]        cl_q;

  logic              wait_zero;
  logic              ld;
  logic [CNT_W-1:0]  ld_val;
  logic [ADDR_W-1:0] base_w, mrs_w;
  logic              legal_in;
  logic              last_ref;

  assign legal_in = cfg_legal(cfg_bus64, cfg_bl8, cfg_cl);
  assign last_ref = (ref_q == REF_W'(REF_N));

  sdram_cfg_chk #(
    .ADDR_W(ADDR_W), .AREA2_BASE(AREA2_BASE), .AREA3_BASE(AREA3_BASE)
  ) u_cfg (
    .area3(area3_q), .bus64(bus64_q), .cl(cl_q),
    .base(base_w), .mrs_addr(mrs_w)
  );

  sdram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .zero(wait_zero)
  );

  // Delay reload at each command issue
  always_comb begin
    ld     = 1'b0;
    ld_val = '0;
    unique case (state_q)
      ST_WAIT: if (start && legal_in) begin ld = 1'b1; ld_val = CNT_W'(IDLE_LD); end
      ST_PWR:  if (wait_zero) begin ld = 1'b1; ld_val = CNT_W'(T_RP); end
      ST_RP:   if (wait_zero) begin ld = 1'b1; ld_val = CNT_W'(T_RFC); end
      ST_RFC:  if (wait_zero) begin
                 ld     = 1'b1;
                 ld_val = last_ref ? CNT_W'(T_MRD) : CNT_W'(T_RFC);
               end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ref_q   <= '0;
      area3_q <= 1'b0;
      bus64_q <= 1'b0;
      cl_q    <= 2'd1;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      unique case (state_q)
        ST_WAIT: if (start) begin
          if (legal_in) begin
            err_q   <= 1'b0;
            area3_q <= cfg_area3;
            bus64_q <= cfg_bus64;
            cl_q    <= cfg_cl;
            state_q <= ST_PWR;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_PWR: if (wait_zero) begin
          cmd_q   <= CMD_PALL;
          addr_q  <= base_w | A10;
          state_q <= ST_RP;
        end
        ST_RP: if (wait_zero) begin
          cmd_q   <= CMD_REF;
          addr_q  <= base_w;
          ref_q   <= REF_W'(1);
          state_q <= ST_RFC;
        end
        ST_RFC: if (wait_zero) begin
          if (last_ref) begin
            cmd_q   <= CMD_MRS;
            addr_q  <= mrs_w;
            state_q <= ST_MRD;
          end else begin
            cmd_q   <= CMD_REF;
            addr_q  <= base_w;
            ref_q   <= ref_q + 1'b1;
          end
        end
        ST_MRD: if (wait_zero) begin
          done_q  <= 1'b1;
          state_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr    = addr_q;
  assign done    = done_q;
  assign cfg_err = err_q;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              done,
  input logic              cfg_err
);
  logic [3:0] pins;
  logic [7:0] refs_seen;
  logic       pall_seen;

  assign pins = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      refs_seen <= '0;
      pall_seen <= 1'b0;
    end else begin
      if (pins == CMD_REF && refs_seen != 8'hFF) refs_seen <= refs_seen + 1'b1;
      if (pins == CMD_PALL) pall_seen <= 1'b1;
    end
  end

  // R7
  legal_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (pins == CMD_NOP || pins == CMD_PALL || pins == CMD_REF || pins == CMD_MRS));

  // R6
  pall_a10_chk: assert property (@(posedge clk) disable iff (rst)
    (pins == CMD_PALL) |-> addr[10]);

  // R3
  nop_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (pins == CMD_NOP) |-> (addr == '0));

  // R4
  mrs_after_refs_chk: assert property (@(posedge clk) disable iff (rst)
    (pins == CMD_MRS) |-> (pall_seen && refs_seen >= 8'd8));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R8
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (pins == CMD_NOP));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (pins == CMD_NOP && !pall_seen));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W)) u_seq_chk (.*);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cfg_area3 = 1'b0, cfg_bus64 = 1'b0, cfg_bl8 = 1'b0;
  logic [1:0] cfg_cl = 2'd1;

  logic [1:0]  cs_n, ras_n, cas_n, we_n, done, cfg_err;
  logic [31:0] addr_o [2];

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_init_seq #(
    .IDLE_CYC(25), .SKIP_IDLE(1'b0), .REF_CNT(9), .T_RP(2), .T_RFC(4), .T_MRD(3)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_area3(cfg_area3), .cfg_bus64(cfg_bus64),
    .cfg_bl8(cfg_bl8), .cfg_cl(cfg_cl), .cs_n(cs_n[0]), .ras_n(ras_n[0]), .cas_n(cas_n[0]),
    .we_n(we_n[0]), .addr(addr_o[0]), .done(done[0]), .cfg_err(cfg_err[0])
  );

  sdram_init_seq #(
    .IDLE_CYC(1000), .SKIP_IDLE(1'b1), .REF_CNT(3), .T_RP(1), .T_RFC(1), .T_MRD(1)
  ) dut_c (
    .clk(clk), .rst(rst), .start(start), .cfg_area3(cfg_area3), .cfg_bus64(cfg_bus64),
    .cfg_bl8(cfg_bl8), .cfg_cl(cfg_cl), .cs_n(cs_n[1]), .ras_n(ras_n[1]), .cas_n(cas_n[1]),
    .we_n(we_n[1]), .addr(addr_o[1]), .done(done[1]), .cfg_err(cfg_err[1])
  );

  // Parameters of each instance, as the bench knows them
  function automatic int p_idle(int d); return d == 0 ? 25 : 0; endfunction
  function automatic int p_nref(int d); return d == 0 ? 9 : 8; endfunction
  function automatic int p_rp(int d);   return d == 0 ? 2 : 1; endfunction
  function automatic int p_rfc(int d);  return d == 0 ? 4 : 1; endfunction
  function automatic int p_mrd(int d);  return d == 0 ? 3 : 1; endfunction

  function automatic logic [31:0] exp_base(logic a3);
    return a3 ? 32'hFF94_0000 : 32'hFF90_0000;
  endfunction

  function automatic logic [31:0] exp_mrs(logic a3, logic b64, logic [1:0] cl);
    logic [31:0] m;
    m = (32'(cl) << 4) | 32'h2;
    return exp_base(a3) + (b64 ? (m << 3) : (m << 2));
  endfunction

  // Command log, filled on the falling edge
  logic [3:0]  lg_cmd  [2][32];
  logic [31:0] lg_addr [2][32];
  int          lg_cyc  [2][32];
  int          lg_n    [2];
  int          done_cyc[2];

  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (rst) begin
        lg_n[d] = 0;
        done_cyc[d] = -1;
      end else begin
        if ({cs_n[d], ras_n[d], cas_n[d], we_n[d]} != 4'b0111) begin
          if (lg_n[d] < 32) begin
            lg_cmd[d][lg_n[d]]  = {cs_n[d], ras_n[d], cas_n[d], we_n[d]};
            lg_addr[d][lg_n[d]] = addr_o[d];
            lg_cyc[d][lg_n[d]]  = cyc;
          end
          lg_n[d]++;
        end
        if (done[d] && done_cyc[d] < 0) done_cyc[d] = cyc;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_run(int s, logic a3, logic b64, logic [1:0] cl);
    for (int d = 0; d < 2; d++) begin
      int t;
      int nr;
      nr = p_nref(d);
      chk(lg_n[d] == nr + 2, "R3", "command count", lg_n[d], nr + 2);
      if (lg_n[d] == nr + 2) begin
        t = s + p_idle(d) + 1;
        chk(lg_cmd[d][0] == 4'b0010, "R7", "precharge code", lg_cmd[d][0], 4'b0010);
        chk(lg_cyc[d][0] == t, "R2", "precharge cycle", lg_cyc[d][0], t);
        chk(lg_addr[d][0] == (exp_base(a3) | 32'h400), "R6", "precharge addr",
            lg_addr[d][0], exp_base(a3) | 32'h400);
        t += p_rp(d) + 1;
        for (int i = 1; i <= nr; i++) begin
          chk(lg_cmd[d][i] == 4'b0001, "R4", "refresh code", lg_cmd[d][i], 4'b0001);
          chk(lg_cyc[d][i] == t, "R5", "refresh cycle", lg_cyc[d][i], t);
          chk(lg_addr[d][i] == exp_base(a3), "R6", "refresh addr", lg_addr[d][i], exp_base(a3));
          t += p_rfc(d) + 1;
        end
        chk(lg_cmd[d][nr+1] == 4'b0000, "R7", "mode set code", lg_cmd[d][nr+1], 4'b0000);
        chk(lg_cyc[d][nr+1] == t, "R5", "mode set cycle", lg_cyc[d][nr+1], t);
        chk(lg_addr[d][nr+1] == exp_mrs(a3, b64, cl), "R6", "mode set addr",
            lg_addr[d][nr+1], exp_mrs(a3, b64, cl));
        t += p_mrd(d) + 1;
        chk(done_cyc[d] == t, "R5", "done cycle", done_cyc[d], t);
      end
      chk(done[d] == 1'b1, "R8", "done held", done[d], 1);
    end
  endtask

  task automatic run_legal(logic a3, logic b64, logic [1:0] cl, bit hit_mid);
    int s;
    int n;
    @(negedge clk);
    cfg_area3 = a3; cfg_bus64 = b64; cfg_bl8 = b64; cfg_cl = cl;
    start = 1'b1;
    s = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err == 2'b00, "R9", "error clear on legal start", cfg_err, 0);
    if (hit_mid) begin
      // R8: mid-run start with another config must be ignored
      repeat (3) @(negedge clk);
      cfg_area3 = ~a3; cfg_cl = (cl == 2'd3) ? 2'd1 : cl + 2'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (done != 2'b11 && n < 400) begin
      @(negedge clk);
      n++;
    end
    // R8: start after done must be ignored
    repeat (2) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check_run(s, a3, b64, cl);
  endtask

  task automatic run_illegal(logic b64, logic bl8, logic [1:0] cl);
    @(negedge clk);
    cfg_area3 = 1'b0; cfg_bus64 = b64; cfg_bl8 = bl8; cfg_cl = cl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err == 2'b11, "R9", "error flag set", cfg_err, 2'b11);
    repeat (40) @(negedge clk);
    chk(lg_n[0] == 0 && lg_n[1] == 0, "R9", "no command on illegal cfg", lg_n[0] + lg_n[1], 0);
    chk(done == 2'b00, "R9", "done low on illegal cfg", done, 0);
    chk(cfg_err == 2'b11, "R9", "error flag held", cfg_err, 2'b11);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_1234);
    do_reset();
    // R1: reset values
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk({cs_n[d], ras_n[d], cas_n[d], we_n[d]} == 4'b0111, "R1", "pins at reset",
          {cs_n[d], ras_n[d], cas_n[d], we_n[d]}, 4'b0111);
      chk(addr_o[d] == 0, "R1", "addr at reset", addr_o[d], 0);
      chk(done[d] == 0 && cfg_err[d] == 0, "R1", "flags at reset", {done[d], cfg_err[d]}, 0);
    end

    // Directed corners: the two worked offsets
    do_reset();
    run_legal(1'b0, 1'b0, 2'd1, 1'b0);
    do_reset();
    run_legal(1'b0, 1'b1, 2'd1, 1'b1);

    // Illegal configs, then recovery without reset
    do_reset();
    run_illegal(1'b0, 1'b1, 2'd2);
    run_illegal(1'b1, 1'b1, 2'd0);
    run_illegal(1'b1, 1'b0, 2'd3);
    run_legal(1'b1, 1'b1, 2'd3, 1'b1);

    // Random legal configurations
    for (int k = 0; k < 12; k++) begin
      logic a3, b64;
      logic [1:0] cl;
      a3  = 1'($urandom);
      b64 = 1'($urandom);
      cl  = 2'($urandom_range(3, 1));
      do_reset();
      run_legal(a3, b64, cl, 1'($urandom));
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule